// File: doc/BRIEF.md
# Dual-Rail Power Sequencer

This block is the control state machine for a display supply made of a positive boost converter and a negative inverting converter. When enable is high and the supply is valid, it first charges the boost output through a current-limited switch. Once the boost output reaches the input voltage, it starts the boost soft-start. After a programmed delay it starts the inverting soft-start, and a fixed time after start-up began it declares both rails in regulation. While the rails are up it watches the protection comparators. A short-circuit, an overload, or a short found during the positive soft-start parks the block in a latched fault. Overtemperature and undervoltage shut the rails down without latching. When enable falls, an optional timed discharge runs before the outputs are released.

All comparator inputs and the two control pins pass through a synchronizer. All delays are counts of a millisecond tick that a prescaler derives from the clock. The current phase and the cause of the last protective shutdown are reported as encoded outputs.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, every converter control, the discharge control and power-good are low, `state_o` is 0 (off) and `cause_o` is 0 (none).
- R2: In state 0, with `en_i` high and neither `uvlo_i` nor `otp_i` high, the block enters precharge (state 1). Precharge drives `inrush_lim_o` high and both converter enables low. It lasts until `mid_ok_i` is seen high, and then moves to boost soft-start (state 2), which drives `boost_en_o` and `boost_ss_o` high.
- R3: The inverting converter is enabled (state 3, `inv_en_o` and `inv_ss_o` high) NEG_DELAY_MS ticks after boost soft-start is entered. It is never enabled while the boost converter is off.
- R4: The block enters regulation (state 4, `pgood_o` high, both soft-start outputs low) once REG_MS ticks have passed since precharge was entered and the inverting rail has started.
- R5: `ss_short_i` during boost soft-start moves the block to the fault state (6) with cause 1, before the inverting rail starts. In any other state, `ss_short_i` has no effect.
- R6: In states 1 to 4, `scp_i` forces state 6 with cause 3, and `ovl_i` forces state 6 with cause 2. If several flags are high together, the order of precedence is: short-circuit, then overload, then soft-start short, then overtemperature, then undervoltage, then enable low. State 6 holds with every output off, even after the flag clears, until `en_i` goes low. Then the block goes to state 0.
- R7: `otp_i` in states 1 to 4 moves the block to state 0 with cause 4. The block restarts on its own once `otp_i` clears while `en_i` is still high.
- R8: `uvlo_i` keeps the block in state 0 and shuts down states 1 to 4 to state 0. It leaves `cause_o` unchanged, and start-up resumes when it clears.
- R9: `en_i` low in states 1 to 4 with `dis_off_i` low enters discharge (state 5). This state drives `disch_o` high with both converters off, lasts DIS_MS ticks, and then goes to state 0.
- R10: `en_i` low in states 1 to 4 with `dis_off_i` high goes straight to state 0, and `disch_o` stays low.
- R11: `cause_o` holds its value through state 0 and regulation, and returns to 0 when precharge is next entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable pin, high turns the rails on |
| dis_off_i | input | 1 | High disables the output discharge at shutdown |
| uvlo_i | input | 1 | Supply below threshold (hysteresis applied by the comparator) |
| otp_i | input | 1 | Junction over temperature (hysteresis applied by the comparator) |
| mid_ok_i | input | 1 | Boost output has reached the input voltage |
| ss_short_i | input | 1 | Short found during positive soft-start |
| ovl_i | input | 1 | Overload on an output |
| scp_i | input | 1 | Short-circuit on an output |
| boost_en_o | output | 1 | Boost converter switching enable |
| boost_ss_o | output | 1 | Boost soft-start active |
| inv_en_o | output | 1 | Inverting converter switching enable |
| inv_ss_o | output | 1 | Inverting soft-start active |
| inrush_lim_o | output | 1 | Current-limited precharge switch control |
| disch_o | output | 1 | Output discharge switch control |
| pgood_o | output | 1 | Both rails in regulation |
| state_o | output | 3 | Phase: 0 off, 1 precharge, 2 boost ss, 3 both ss, 4 regulation, 5 discharge, 6 fault |
| cause_o | output | 3 | Sticky cause: 0 none, 1 ss short, 2 overload, 3 short, 4 over temperature |

## Verification
The hardest case to reach is the soft-start short. It counts only in the short boost-only window before the inverting delay expires, and that window shrinks to a few clocks once the synchronizer latency is taken into account. The bench waits until it sees state 2, raises the flag on that same sampling edge, and then checks that the fault latches with the inverting enable never raised. A random phase starts the block again and again with a fixed seed. Each pass injects one of the five shutdown causes, with a random discharge setting, and compares the resulting state and cause against a bench-side model.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_PRECHG   = 3'd1,
        ST_BOOST_SS = 3'd2,
        ST_BOTH_SS  = 3'd3,
        ST_RUN      = 3'd4,
        ST_DISCHG   = 3'd5,
        ST_FAULT    = 3'd6
    } seq_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_SS_SHORT = 3'd1,
        CAUSE_OVERLOAD = 3'd2,
        CAUSE_SHORT    = 3'd3,
        CAUSE_OTP      = 3'd4
    } fault_cause_e;

    // synchronized pin and comparator bundle
    typedef struct packed {
        logic en;
        logic dis_off;
        logic uvlo;
        logic otp;
        logic mid_ok;
        logic ss_short;
        logic ovl;
        logic scp;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

endpackage

// File: rtl/rail_seq_sync.sv
module rail_seq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stage_q;
    logic [STAGES-1:0][W-1:0] stage_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stage_d = async_i;
        end else begin : g_chain
            always_comb stage_d = {stage_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rail_seq_tick.sv
module rail_seq_tick #(
    parameter int CLKS_PER_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int CW = $clog2(CLKS_PER_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        tick_d = (cnt_q == LAST);
        cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int NEG_DELAY_MS = 2,
    parameter int REG_MS       = 13,
    parameter int DIS_MS       = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  flags_t       flags_i,
    output seq_state_e   state_o,
    output fault_cause_e cause_o
);

    localparam int MAXD0 = (REG_MS > DIS_MS) ? REG_MS : DIS_MS;
    localparam int MAXD  = (MAXD0 > NEG_DELAY_MS) ? MAXD0 : NEG_DELAY_MS;
    localparam int TW    = $clog2(MAXD + 2);
    localparam logic [TW-1:0] NEG_T = TW'(NEG_DELAY_MS);
    localparam logic [TW-1:0] REG_T = TW'(REG_MS);
    localparam logic [TW-1:0] DIS_T = TW'(DIS_MS);
    localparam logic [TW-1:0] SAT_T = '1;

    typedef struct packed {
        seq_state_e   st;
        fault_cause_e cause;
        logic [TW-1:0] tmr;
        logic [TW-1:0] elapsed;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      active;

    always_comb begin
        r_d    = r_q;
        active = (r_q.st == ST_PRECHG) || (r_q.st == ST_BOOST_SS) ||
                 (r_q.st == ST_BOTH_SS) || (r_q.st == ST_RUN);

        // normal progression
        case (r_q.st)
            ST_OFF:      if (flags_i.en && !flags_i.uvlo && !flags_i.otp) r_d.st = ST_PRECHG;
            ST_PRECHG:   if (flags_i.mid_ok)      r_d.st = ST_BOOST_SS;
            ST_BOOST_SS: if (r_q.tmr >= NEG_T)    r_d.st = ST_BOTH_SS;
            ST_BOTH_SS:  if (r_q.elapsed >= REG_T) r_d.st = ST_RUN;
            ST_DISCHG:   if (r_q.tmr >= DIS_T)    r_d.st = ST_OFF;
            ST_FAULT:    if (!flags_i.en)         r_d.st = ST_OFF;
            default:     r_d.st = r_q.st;
        endcase

        // protection and shutdown, in priority order
        if (active) begin
            if (flags_i.scp) begin
                r_d.st    = ST_FAULT;
                r_d.cause = CAUSE_SHORT;
            end else if (flags_i.ovl) begin
                r_d.st    = ST_FAULT;
                r_d.cause = CAUSE_OVERLOAD;
            end else if (flags_i.ss_short && r_q.st == ST_BOOST_SS) begin
                r_d.st    = ST_FAULT;
                r_d.cause = CAUSE_SS_SHORT;
            end else if (flags_i.otp) begin
                r_d.st    = ST_OFF;
                r_d.cause = CAUSE_OTP;
            end else if (flags_i.uvlo) begin
                r_d.st    = ST_OFF;
            end else if (!flags_i.en) begin
                r_d.st    = flags_i.dis_off ? ST_OFF : ST_DISCHG;
            end
        end

        // phase timer restarts on every state change
        if (r_d.st != r_q.st)              r_d.tmr = '0;
        else if (tick_i && r_q.tmr != SAT_T) r_d.tmr = r_q.tmr + 1'b1;

        // start-up timer and cause clear at precharge entry
        if (r_d.st == ST_PRECHG && r_q.st != ST_PRECHG) begin
            r_d.elapsed = '0;
            r_d.cause   = CAUSE_NONE;
        end else if (tick_i && r_q.elapsed != SAT_T) begin
            r_d.elapsed = r_q.elapsed + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_OFF;
            r_q.cause   <= CAUSE_NONE;
            r_q.tmr     <= '0;
            r_q.elapsed <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign cause_o = r_q.cause;

endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
    import rail_seq_pkg::*;
#(
    parameter int CLKS_PER_MS  = 1000,
    parameter int SYNC_STAGES  = 2,
    parameter int NEG_DELAY_MS = 2,
    parameter int REG_MS       = 13,
    parameter int DIS_MS       = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       dis_off_i,
    input  logic       uvlo_i,
    input  logic       otp_i,
    input  logic       mid_ok_i,
    input  logic       ss_short_i,
    input  logic       ovl_i,
    input  logic       scp_i,
    output logic       boost_en_o,
    output logic       boost_ss_o,
    output logic       inv_en_o,
    output logic       inv_ss_o,
    output logic       inrush_lim_o,
    output logic       disch_o,
    output logic       pgood_o,
    output logic [2:0] state_o,
    output logic [2:0] cause_o
);

    flags_t       raw_flags, sync_flags;
    logic         tick;
    seq_state_e   st;
    fault_cause_e cause;

    always_comb begin
        raw_flags.en       = en_i;
        raw_flags.dis_off  = dis_off_i;
        raw_flags.uvlo     = uvlo_i;
        raw_flags.otp      = otp_i;
        raw_flags.mid_ok   = mid_ok_i;
        raw_flags.ss_short = ss_short_i;
        raw_flags.ovl      = ovl_i;
        raw_flags.scp      = scp_i;
    end

    rail_seq_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_flags),
        .sync_o  (sync_flags)
    );

    rail_seq_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rail_seq_fsm #(
        .NEG_DELAY_MS (NEG_DELAY_MS),
        .REG_MS       (REG_MS),
        .DIS_MS       (DIS_MS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .flags_i (sync_flags),
        .state_o (st),
        .cause_o (cause)
    );

    // output decode from the registered state
    always_comb begin
        boost_en_o   = (st == ST_BOOST_SS) || (st == ST_BOTH_SS) || (st == ST_RUN);
        boost_ss_o   = (st == ST_BOOST_SS) || (st == ST_BOTH_SS);
        inv_en_o     = (st == ST_BOTH_SS) || (st == ST_RUN);
        inv_ss_o     = (st == ST_BOTH_SS);
        inrush_lim_o = (st == ST_PRECHG);
        disch_o      = (st == ST_DISCHG);
        pgood_o      = (st == ST_RUN);
        state_o      = st;
        cause_o      = cause;
    end

endmodule

// File: rtl/rail_seq_checker.sv
module rail_seq_checker
    import rail_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       boost_en_o,
    input logic       inv_en_o,
    input logic       inrush_lim_o,
    input logic       disch_o,
    input logic       pgood_o,
    input logic [2:0] state_o,
    input logic [2:0] cause_o
);

    assert_boost_after_precharge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boost_en_o) |-> $past(inrush_lim_o));

    assert_inv_after_boost_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_en_o) |-> $past(boost_en_o));

    assert_pgood_after_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood_o) |-> $past(inv_en_o));

    assert_ss_fault_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state_o == ST_FAULT) && cause_o == CAUSE_SS_SHORT) |-> $past(state_o) == ST_BOOST_SS);

    assert_fault_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == ST_FAULT |=> (state_o == ST_FAULT || state_o == ST_OFF));

    assert_discharge_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disch_o |-> (!boost_en_o && !inv_en_o));

    assert_cause_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RUN && $past(state_o) == ST_RUN) |-> $stable(cause_o));

endmodule

bind rail_seq_top rail_seq_checker u_chk (.*);

// File: tb/rail_seq_top_test.sv
module rail_seq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int P   = 4;
    localparam int NEG = 2;
    localparam int REG = 13;
    localparam int DIS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 0, dis_off_i = 0, uvlo_i = 0, otp_i = 0;
    logic mid_ok_i = 0, ss_short_i = 0, ovl_i = 0, scp_i = 0;
    logic boost_en_o, boost_ss_o, inv_en_o, inv_ss_o, inrush_lim_o, disch_o, pgood_o;
    logic [2:0] state_o, cause_o;

    int checks = 0;
    int failures = 0;

    rail_seq_top #(
        .CLKS_PER_MS(P), .SYNC_STAGES(2), .NEG_DELAY_MS(NEG), .REG_MS(REG), .DIS_MS(DIS)
    ) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_state(input logic [2:0] s, input int maxc, output int n);
        n = 0;
        while (state_o !== s) begin
            @(negedge clk);
            n++;
            if (n > maxc) begin
                n = -1;
                return;
            end
        end
    endtask

    // model of the state after a shutdown event from regulation
    function automatic int exp_state(input int kind, input int dsoff);
        case (kind)
            0, 1:    return 6;
            2, 3:    return 0;
            default: return dsoff ? 0 : 5;
        endcase
    endfunction

    function automatic int exp_cause(input int kind);
        case (kind)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int kind, input int dsoff);
        case (kind)
            0, 1:    return "R6 fault";
            2:       return "R7 overtemp";
            3:       return "R8 undervoltage";
            default: return dsoff ? "R10 no discharge" : "R9 discharge";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        bit saw;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 state", state_o, 0);
        check("R1 cause", cause_o, 0);
        check("R1 outputs", {boost_en_o, boost_ss_o, inv_en_o, inv_ss_o, inrush_lim_o, disch_o, pgood_o}, 0);
        rst_n = 1'b1;

        // R8 start blocked by undervoltage
        uvlo_i = 1; en_i = 1;
        repeat (20) @(negedge clk);
        check("R8 held off", state_o, 0);
        uvlo_i = 0;
        wait_state(1, 10, n);
        check("R2 precharge entered", state_o, 1);
        check("R2 inrush limit", inrush_lim_o, 1);
        check("R2 converters off", {boost_en_o, inv_en_o}, 0);
        repeat (40) @(negedge clk);
        check("R2 precharge waits", state_o, 1);
        mid_ok_i = 1;
        wait_state(2, 10, n);
        check("R2 boost ss", {boost_en_o, boost_ss_o, inv_en_o}, 3'b110);
        wait_state(3, NEG*P + 10, n);
        check_rng("R3 inverting delay", n, (NEG-1)*P, NEG*P + 3);
        check("R3 inverting on", {inv_en_o, inv_ss_o}, 2'b11);
        wait_state(4, REG*P + 10, n);
        check("R4 regulation", {pgood_o, boost_ss_o, inv_ss_o}, 3'b100);

        // R9 discharge on enable fall
        dis_off_i = 0; en_i = 0;
        wait_state(5, 10, n);
        check("R9 discharge on", {disch_o, boost_en_o, inv_en_o}, 3'b100);
        wait_state(0, DIS*P + 10, n);
        check_rng("R9 discharge time", n, (DIS-1)*P, DIS*P + 3);
        check("R9 discharge released", disch_o, 0);

        // R4 timing from precharge entry
        en_i = 1;
        wait_state(1, 10, n);
        wait_state(4, REG*P + 20, n);
        check_rng("R4 regulation time", n, (REG-1)*P, REG*P + 3);

        // R5 soft-start short ignored in regulation
        ss_short_i = 1;
        repeat (8) @(negedge clk);
        check("R5 ignored outside boost ss", state_o, 4);
        ss_short_i = 0;

        // R10 no discharge
        dis_off_i = 1; en_i = 0;
        saw = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (disch_o || state_o == 5) saw = 1;
        end
        check("R10 state off", state_o, 0);
        check("R10 discharge never", saw, 0);

        // R5 short during boost soft-start, R6 latch, R11 sticky cause
        en_i = 1;
        wait_state(2, 20, n);
        ss_short_i = 1;
        saw = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (inv_en_o) saw = 1;
        end
        check("R5 fault state", state_o, 6);
        check("R5 fault cause", cause_o, 1);
        check("R5 inverting never", saw, 0);
        ss_short_i = 0;
        repeat (20) @(negedge clk);
        check("R6 latched", state_o, 6);
        check("R6 outputs off", {boost_en_o, inv_en_o, disch_o}, 0);
        en_i = 0;
        wait_state(0, 10, n);
        check("R6 release on enable low", state_o, 0);
        check("R11 cause held off", cause_o, 1);
        en_i = 1;
        wait_state(2, 20, n);
        check("R11 cause cleared", cause_o, 0);
        wait_state(4, REG*P + 20, n);

        // R7 overtemperature auto restart
        otp_i = 1;
        repeat (6) @(negedge clk);
        check("R7 off", state_o, 0);
        check("R7 cause", cause_o, 4);
        otp_i = 0;
        wait_state(4, REG*P + 30, n);
        check("R7 restart", (n >= 0) ? 1 : 0, 1);
        check("R7 cause cleared", cause_o, 0);
        en_i = 0; dis_off_i = 1;
        wait_state(0, 20, n);

        // random shutdown events from regulation
        for (int it = 0; it < 16; it++) begin
            int kind, dsoff;
            kind  = $urandom_range(4);
            dsoff = $urandom_range(1);
            en_i = 1;
            wait_state(4, REG*P + 30, n);
            check("R4 random start", (n >= 0) ? 1 : 0, 1);
            dis_off_i = dsoff[0];
            case (kind)
                0: ovl_i = 1;
                1: scp_i = 1;
                2: otp_i = 1;
                3: uvlo_i = 1;
                default: en_i = 0;
            endcase
            repeat (6) @(negedge clk);
            check({req_of(kind, dsoff), " state"}, state_o, exp_state(kind, dsoff));
            check({req_of(kind, dsoff), " cause"}, cause_o, exp_cause(kind));
            ovl_i = 0; scp_i = 0; otp_i = 0; uvlo_i = 0; en_i = 0;
            wait_state(0, DIS*P + 20, n);
            check("R6 random return off", state_o, 0);
            repeat (3) @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule